// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a small synchronous single-port memory that stores one bit per address. It serves as the device under test when memory self-test logic is developed or checked. Reads and writes enter on a request channel. A separate configuration port arms at most one functional fault at a time. The fault is described by a kind code, a victim address, an aggressor address, a polarity bit and a forced value. Every access is evaluated against the armed fault, and the stored contents or the returned bit are altered to match that fault's behaviour.

The request channel is valid/ready. `req_ready` is held high in every cycle, so a request is taken on each rising edge where `req_valid` is high, and the request port never applies back-pressure. A read produces exactly one response, on `rsp_valid`/`rsp_data`, in the cycle after it is accepted. A write produces no response. The response channel has no ready signal: the consumer must take each response in the cycle it appears. A 16-bit LFSR runs freely and supplies the unpredictable bit that a read of an aliased address returns.

`DEPTH` must be a power of two. For the coupling, bridging and aliasing kinds, the victim and aggressor addresses must differ.

Top module: `fault_bit_ram`

## Requirements
- R1: After reset every cell reads 0, the armed fault is kind 0 (fault-free) and `rsp_valid` is low.
- R2: `req_ready` is always 1. A read accepted in cycle N raises `rsp_valid` with its data in cycle N+1. A write raises no response.
- R3: With kind 0, or with any unused code 10 to 15, a read returns the value most recently written to that address.
- R4: The configuration is loaded on an edge where `cfg_we` is 1 and `req_valid` is 0. A `cfg_we` pulse that arrives together with a request is ignored.
- R5: Kind 1 (stuck-at): reads of the victim return `cfg_val`, and writes to the victim leave its cell unchanged.
- R6: Kind 2 (transition): with `cfg_pol`=0 a 0-to-1 write to the victim is dropped; with `cfg_pol`=1 a 1-to-0 write is dropped. Writes in the other direction take effect.
- R7: Kind 3 (inversion coupling): a write that moves the aggressor 0-to-1 (`cfg_pol`=0) or 1-to-0 (`cfg_pol`=1) inverts the victim cell.
- R8: Kind 4 (idempotent coupling): the same aggressor transition as in R7 sets the victim cell to `cfg_val`.
- R9: Kind 5 (dynamic coupling): any access to the aggressor whose data equals `cfg_pol` sets the victim cell to `cfg_val`. For a write the data is the write data; for a read it is the aggressor's stored bit.
- R10: Kind 6 (state coupling): while the aggressor cell holds `cfg_pol`, reads of the victim return `cfg_val`. Otherwise they return the victim's stored bit.
- R11: Kind 7 makes reads of either bridged cell return the AND of both stored bits. Kind 8 makes them return the OR.
- R12: Kind 9 (aliasing): accesses to the victim address act on the aggressor cell, accesses to the aggressor address act on the victim cell, and a read of the victim address returns the LFSR's low bit.
- R13: The LFSR is 16 bits wide, loads the `LFSR_SEED` parameter at reset and steps every cycle. It never reaches zero, so an aliased victim read returns both 0 and 1 over a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 1 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 1 | Read response bit |
| cfg_we | input | 1 | Load fault configuration |
| cfg_kind | input | 4 | Fault kind code |
| cfg_victim | input | AW | Victim address |
| cfg_aggr | input | AW | Aggressor address |
| cfg_pol | input | 1 | Direction, state or data selector |
| cfg_val | input | 1 | Value forced onto the victim |

## Verification
The assertions check these behaviours on every cycle:
- the one-cycle read response timing;
- that the configuration does not move while a request is present;
- the stuck-at read value;
- a blocked upward transition;
- clean write-through in kind 0;
- redirection of an aliased write;
- that the LFSR never reaches zero.

The coupling and bridging kinds depend on the order in which the victim and the aggressor are touched. They show only through the bench's mixed sequences, which are biased toward the two addresses and compared against a reference memory model. The bench also checks that an aliased read is unpredictable, by seeing that both values appear across the run.

// File: rtl/fbram_pkg.sv
package fbram_pkg;
  localparam logic [3:0] K_NONE  = 4'd0;
  localparam logic [3:0] K_STUCK = 4'd1;
  localparam logic [3:0] K_TRANS = 4'd2;
  localparam logic [3:0] K_INV   = 4'd3;
  localparam logic [3:0] K_IDEM  = 4'd4;
  localparam logic [3:0] K_DYN   = 4'd5;
  localparam logic [3:0] K_STATE = 4'd6;
  localparam logic [3:0] K_AND   = 4'd7;
  localparam logic [3:0] K_OR    = 4'd8;
  localparam logic [3:0] K_ALIAS = 4'd9;

  typedef struct packed {
    logic [3:0] kind;
    logic       pol;
    logic       val;
  } fault_mode_t;
endpackage

// File: rtl/fbram_lfsr.sv
module fbram_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter logic [15:0] TAPS  = 16'hB400
) (
  input  logic clk,
  input  logic rst_n,
  output logic rnd_bit
);
  logic [WIDTH-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED[WIDTH-1:0];
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS[WIDTH-1:0];
    else state_q <= state_q >> 1;
  end

  assign rnd_bit = state_q[0];

  // R13
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/fbram_cfg.sv
module fbram_cfg
  import fbram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          busy,
  input  logic [3:0]    cfg_kind,
  input  logic [AW-1:0] cfg_victim,
  input  logic [AW-1:0] cfg_aggr,
  input  logic          cfg_pol,
  input  logic          cfg_val,
  output fault_mode_t   mode,
  output logic [AW-1:0] victim,
  output logic [AW-1:0] aggr
);
  fault_mode_t   mode_q;
  logic [AW-1:0] victim_q, aggr_q;
  logic          load;

  assign load = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '{kind: K_NONE, pol: 1'b0, val: 1'b0};
      victim_q <= '0;
      aggr_q   <= '0;
    end else if (load) begin
      mode_q   <= '{kind: cfg_kind, pol: cfg_pol, val: cfg_val};
      victim_q <= cfg_victim;
      aggr_q   <= cfg_aggr;
    end
  end

  assign mode   = mode_q;
  assign victim = victim_q;
  assign aggr   = aggr_q;

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_q) && $stable(victim_q) && $stable(aggr_q)));
endmodule

// File: rtl/fbram_fault.sv
module fbram_fault
  import fbram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             fire,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic             wdata,
  input  fault_mode_t      mode,
  input  logic [AW-1:0]    victim,
  input  logic [AW-1:0]    aggr,
  input  logic [DEPTH-1:0] cells,
  input  logic             rnd_bit,
  output logic             wr_en,
  output logic [AW-1:0]    wr_idx,
  output logic             wr_bit,
  output logic             vic_en,
  output logic             vic_bit,
  output logic             rd_bit
);
  logic          hit_v, hit_a;
  logic [AW-1:0] phys;
  logic          cur, cur_v, cur_a;
  logic          aggr_edge, victim_blocked, dyn_data;

  assign hit_v = (addr == victim);
  assign hit_a = (addr == aggr);

  always_comb begin
    phys = addr;
    if (mode.kind == K_ALIAS) begin
      if (hit_v)      phys = aggr;
      else if (hit_a) phys = victim;
    end
  end

  assign cur   = cells[phys];
  assign cur_v = cells[victim];
  assign cur_a = cells[aggr];

  // write on the aggressor that moves it in the selected direction
  assign aggr_edge      = we && hit_a && (mode.pol ? (cur_a && !wdata) : (!cur_a && wdata));
  assign victim_blocked = mode.pol ? (cur_v && !wdata) : (!cur_v && wdata);
  assign dyn_data       = we ? wdata : cur_a;

  always_comb begin
    wr_en   = fire && we;
    wr_idx  = phys;
    wr_bit  = wdata;
    vic_en  = 1'b0;
    vic_bit = 1'b0;
    rd_bit  = cur;
    case (mode.kind)
      K_STUCK: if (hit_v) begin
        wr_en  = 1'b0;
        rd_bit = mode.val;
      end
      K_TRANS: if (hit_v && we && victim_blocked) wr_en = 1'b0;
      K_INV: if (fire && aggr_edge) begin
        vic_en  = 1'b1;
        vic_bit = !cur_v;
      end
      K_IDEM: if (fire && aggr_edge) begin
        vic_en  = 1'b1;
        vic_bit = mode.val;
      end
      K_DYN: if (fire && hit_a && (dyn_data == mode.pol)) begin
        vic_en  = 1'b1;
        vic_bit = mode.val;
      end
      K_STATE: if (hit_v && (cur_a == mode.pol)) rd_bit = mode.val;
      K_AND:   if (hit_v || hit_a) rd_bit = cur_v & cur_a;
      K_OR:    if (hit_v || hit_a) rd_bit = cur_v | cur_a;
      K_ALIAS: if (hit_v) rd_bit = rnd_bit;
      default: ;
    endcase
  end
endmodule

// File: rtl/fault_bit_ram.sv
module fault_bit_ram
  import fbram_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          rsp_valid,
  output logic          rsp_data,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_kind,
  input  logic [AW-1:0] cfg_victim,
  input  logic [AW-1:0] cfg_aggr,
  input  logic          cfg_pol,
  input  logic          cfg_val
);
  logic [DEPTH-1:0] cells;
  fault_mode_t      mode;
  logic [AW-1:0]    victim, aggr;
  logic             rnd_bit, fire;
  logic             wr_en, wr_bit, vic_en, vic_bit, rd_bit;
  logic [AW-1:0]    wr_idx;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;

  fbram_lfsr #(.WIDTH(16), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_bit(rnd_bit)
  );

  fbram_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .busy(req_valid),
    .cfg_kind(cfg_kind), .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr),
    .cfg_pol(cfg_pol), .cfg_val(cfg_val),
    .mode(mode), .victim(victim), .aggr(aggr)
  );

  fbram_fault #(.DEPTH(DEPTH), .AW(AW)) u_fault (
    .fire(fire), .we(req_we), .addr(req_addr), .wdata(req_wdata),
    .mode(mode), .victim(victim), .aggr(aggr), .cells(cells),
    .rnd_bit(rnd_bit),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(wr_bit),
    .vic_en(vic_en), .vic_bit(vic_bit), .rd_bit(rd_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells <= '0;
    end else begin
      if (wr_en)  cells[wr_idx] <= wr_bit;
      if (vic_en) cells[victim] <= vic_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 1'b0;
    end else begin
      rsp_valid <= fire && !req_we;
      if (fire && !req_we) rsp_data <= rd_bit;
    end
  end

  // R2
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  // R2
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);
  // R5
  stuck_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && mode.kind == K_STUCK && req_addr == victim)
      |=> (rsp_data == $past(mode.val)));
  // R6
  trans_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && mode.kind == K_TRANS && !mode.pol &&
     req_addr == victim && !cells[victim]) |=> !cells[$past(victim)]);
  // R3
  clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && mode.kind == K_NONE)
      |=> (cells[$past(req_addr)] == $past(req_wdata)));
  // R12
  alias_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && mode.kind == K_ALIAS && req_addr == victim)
      |=> (cells[$past(aggr)] == $past(req_wdata)));
endmodule

// File: tb/fault_bit_ram_tb.sv
`timescale 1ns/1ps
module fault_bit_ram_tb;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_we, req_wdata;
  logic [AW-1:0] req_addr, cfg_victim, cfg_aggr;
  logic          rsp_valid, rsp_data, cfg_we, cfg_pol, cfg_val;
  logic [3:0]    cfg_kind;

  fault_bit_ram #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr),
    .cfg_pol(cfg_pol), .cfg_val(cfg_val)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit m[DEPTH];
  logic [3:0] mk = 4'd0;
  int mv = 0, ma = 0;
  bit mp = 0, mval = 0;
  bit seen0 = 0, seen1 = 0;

  function automatic string tag(input logic [3:0] k);
    case (k)
      4'd1: return "R5";
      4'd2: return "R6";
      4'd3: return "R7";
      4'd4: return "R8";
      4'd5: return "R9";
      4'd6: return "R10";
      4'd7, 4'd8: return "R11";
      4'd9: return "R12";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", t, what, act, exp);
    end
  endtask

  // reference model of one access; returns expected read bit
  function automatic bit model(input bit we, input int a, input bit d, output bit rnd);
    int  p;
    bit  r, trig;
    rnd = 0;
    p = a;
    if (mk == 4'd9) begin
      if (a == mv) p = ma;
      else if (a == ma) p = mv;
    end
    r = m[p];
    trig = we && (a == ma) && (mp ? (m[ma] && !d) : (!m[ma] && d));
    case (mk)
      4'd1: if (a == mv) r = mval;
      4'd6: if (a == mv && m[ma] == mp) r = mval;
      4'd7: if (a == mv || a == ma) r = m[mv] & m[ma];
      4'd8: if (a == mv || a == ma) r = m[mv] | m[ma];
      4'd9: if (a == mv) rnd = 1;
      default: ;
    endcase
    if (we) begin
      bit drop;
      drop = (mk == 4'd1 && a == mv) ||
             (mk == 4'd2 && a == mv && (mp ? (m[mv] && !d) : (!m[mv] && d)));
      if (mk == 4'd3 && trig) m[mv] = !m[mv];
      if (mk == 4'd4 && trig) m[mv] = mval;
      if (!drop) m[p] = d;
    end
    if (mk == 4'd5 && a == ma && ((we ? d : m[ma]) == mp)) m[mv] = mval;
    return r;
  endfunction

  task automatic op(input bit we, input int a, input bit d, input string lbl);
    bit exp, rnd;
    exp = model(we, a, d, rnd);
    req_valid = 1; req_we = we; req_addr = a[AW-1:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (we) check("R2", rsp_valid, 1'b0, "response after write");
    else begin
      check("R2", rsp_valid, 1'b1, "response after read");
      if (rnd) begin
        if (rsp_data) seen1 = 1; else seen0 = 1;
      end else check(lbl != "" ? lbl : tag(mk), rsp_data, exp, "read data");
    end
  endtask

  task automatic setcfg(input logic [3:0] k, input int v, input int a, input bit p, input bit val);
    cfg_we = 1; cfg_kind = k; cfg_victim = v[AW-1:0]; cfg_aggr = a[AW-1:0];
    cfg_pol = p; cfg_val = val;
    @(negedge clk);
    cfg_we = 0;
    mk = k; mv = v; ma = a; mp = p; mval = val;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] kinds[11] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd12};
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = 0;
    cfg_we = 0; cfg_kind = '0; cfg_victim = '0; cfg_aggr = '0; cfg_pol = 0; cfg_val = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1", rsp_valid, 1'b0, "rsp_valid after reset");
    check("R2", req_ready, 1'b1, "req_ready");
    for (int i = 0; i < DEPTH; i++) op(0, i, 0, "R1");

    // R4: configuration pulse during an access is ignored
    cfg_we = 1; cfg_kind = 4'd1; cfg_victim = 6'd5; cfg_aggr = 6'd6; cfg_val = 1;
    begin bit r, x; r = model(1, 5, 0, x); end
    req_valid = 1; req_we = 1; req_addr = 6'd5; req_wdata = 0;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    op(0, 5, 0, "R4");
    op(1, 5, 1, "");
    op(0, 5, 0, "R4");

    // R6 directed: both directions
    setcfg(4'd2, 10, 11, 0, 0);
    op(1, 10, 1, ""); op(0, 10, 0, "R6");
    setcfg(4'd0, 10, 11, 0, 0);
    op(1, 10, 1, "");
    setcfg(4'd2, 10, 11, 1, 0);
    op(1, 10, 0, ""); op(0, 10, 0, "R6");
    // R7 directed: aggressor rise flips victim
    setcfg(4'd3, 20, 21, 0, 0);
    op(1, 21, 0, ""); op(1, 21, 1, ""); op(0, 20, 0, "R7");

    foreach (kinds[j]) begin
      int v, a;
      v = int'($urandom % DEPTH);
      a = (v + 1 + int'($urandom % (DEPTH - 1))) % DEPTH;
      setcfg(kinds[j], v, a, bit'($urandom % 2), bit'($urandom % 2));
      repeat (150) begin
        int sel, ad;
        sel = int'($urandom % 4);
        ad = (sel == 0) ? v : (sel == 1) ? a : int'($urandom % DEPTH);
        op(bit'($urandom % 2), ad, bit'($urandom % 2), "");
      end
    end
    // R13: aliased victim reads return both values
    check("R13", seen0 && seen1, 1'b1, "aliased read saw both 0 and 1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule